// File: doc/BRIEF.md
# UART Register Front-End on an APB Slave Port

This block is the software-visible side of a UART, placed on an APB-style slave port. A processor reads and writes five word offsets: data, status, control, scaler and a debug slot. Bytes that arrive on a valid/ready byte stream are queued in a receive FIFO. Software drains that FIFO by reading the data offset. Bytes that software writes to the data offset leave on a second valid/ready byte stream. Serial bit timing, parity and line errors belong to other blocks, so the scaler and debug offsets only hold the address space.

Two small state machines set the timing. The APB phase tracker has three states. `AP_IDLE` waits for a setup phase and moves to `AP_SETUP` when select is high and enable is low. `AP_SETUP` moves to `AP_ACCESS` when enable rises, and that transition is the single commit of the transfer. `AP_ACCESS` returns to `AP_SETUP` on a back-to-back setup phase, and otherwise to `AP_IDLE`. The transmit holder has two states. `TX_IDLE` moves to `TX_HOLD` when an enabled data write loads a byte. `TX_HOLD` returns to `TX_IDLE` on the cycle the stream sink shows ready. A single interrupt line gives one-cycle pulses when a byte is accepted on either path.

Top module: `apb_uart_front`

## Requirements
- R1: While reset is held and right after it, the control word reads 0, the status word reads 0x6, and `irq`, `tx_valid` and `rx_ready` are low.
- R2: Every access completes in its access phase with `pready` high and `pslverr` low. Only address bits [7:0] are decoded. Offsets 0x10 and any unmapped offset read as zero. Each transfer commits exactly once, and only after a setup phase.
- R3: A write to offset 0x08 replaces the whole 32-bit control word, and the word reads back unchanged. Control bit 0 enables receive, bit 1 enables transmit, bit 2 enables the receive interrupt and bit 3 enables the transmit interrupt.
- R4: Writes to status (0x04) and scaler (0x0C) change nothing. Scaler always reads zero.
- R5: `rx_ready` is high only while control bit 0 is set and the FIFO has space. An accepted byte sets status bit 0 (data ready).
- R6: A read at offset 0x00 or 0x03 returns the oldest stored byte in bits [7:0], with zeros above, and removes it. Bytes leave in arrival order.
- R7: A data read of an empty FIFO returns zero, and status bit 0 is clear whenever the FIFO is empty, including right after the last byte is read.
- R8: Status bit 8 is set when at least DEPTH/2 bytes are stored and bit 10 when DEPTH are stored. At DEPTH, `rx_ready` is low, and the held byte is accepted once a read frees a slot.
- R9: A receive push and a data read in the same cycle leave the stored count unchanged and keep FIFO order.
- R10: A data write with control bit 1 set presents bits [7:0] on `tx_data` with `tx_valid` high, held stable until `tx_ready`. While a byte is pending, status bits 1 and 2 are clear and bit 9 is set. Otherwise bits 1 and 2 are set and bit 9 is clear. Status bits 3 to 7 read zero.
- R11: A data write while transmit is disabled, or while a byte is still pending, is dropped: the output does not change and no interrupt is raised.
- R12: `irq` pulses high for the cycle after an accepted receive byte when control bit 2 is set, and after an accepted transmit write when control bit 3 is set. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase marker |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high, so there are no wait states |
| pslverr | output | 1 | Always low |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Block can take the incoming byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Sink takes the outgoing byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with DEPTH set to 4 and ADDR_W set to 12. The shallow FIFO reaches its half and full thresholds after a handful of pushes, which lets the bench exercise back-pressure and refill after a read cheaply. The 12-bit address lets the bench reach aliases above bit 7, such as 0x103 and 0x108, which must decode as their low-byte offsets. A same-cycle push during a data read and a data write while a byte is still pending are both driven on purpose.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DEC_W  = 8;

    localparam logic [DEC_W-1:0] OFS_DATA     = 8'h00;
    localparam logic [DEC_W-1:0] OFS_DATA_ALT = 8'h03;
    localparam logic [DEC_W-1:0] OFS_STAT     = 8'h04;
    localparam logic [DEC_W-1:0] OFS_CTRL     = 8'h08;
    localparam logic [DEC_W-1:0] OFS_SCAL     = 8'h0C;

    localparam int unsigned CTL_RXEN = 0;
    localparam int unsigned CTL_TXEN = 1;
    localparam int unsigned CTL_RXIE = 2;
    localparam int unsigned CTL_TXIE = 3;

    localparam int unsigned STB_DRDY   = 0;
    localparam int unsigned STB_TSHE   = 1;
    localparam int unsigned STB_TFE    = 2;
    localparam int unsigned STB_RXHALF = 8;
    localparam int unsigned STB_TXFULL = 9;
    localparam int unsigned STB_RXFULL = 10;

    typedef enum logic [1:0] {AP_IDLE, AP_SETUP, AP_ACCESS} apb_state_e;
    typedef enum logic       {TX_IDLE, TX_HOLD} tx_state_e;
    typedef enum logic [2:0] {SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_SCAL} reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [DEC_W-1:0] ofs);
        reg_sel_e sel;
        unique case (ofs)
            OFS_DATA, OFS_DATA_ALT: sel = SEL_DATA;
            OFS_STAT:               sel = SEL_STAT;
            OFS_CTRL:               sel = SEL_CTRL;
            OFS_SCAL:               sel = SEL_SCAL;
            default:                sel = SEL_NONE;
        endcase
        return sel;
    endfunction
endpackage

// File: rtl/apb_uart_apb_fsm.sv
module apb_uart_apb_fsm
    import apb_uart_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic commit
);
    apb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AP_IDLE:   if (psel && !penable) state_d = AP_SETUP;
            AP_SETUP: begin
                if (!psel)        state_d = AP_IDLE;
                else if (penable) state_d = AP_ACCESS;
            end
            AP_ACCESS: state_d = (psel && !penable) ? AP_SETUP : AP_IDLE;
            default:   state_d = AP_IDLE;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            AP_SETUP: commit = psel && penable;
            default:  commit = 1'b0;
        endcase
    end

    // R2
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R2
    commit_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(psel && !penable));
endmodule

// File: rtl/apb_uart_rx_fifo.sv
module apb_uart_rx_fifo #(
    parameter  int unsigned DEPTH = 16,
    parameter  int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem_q[rd_ptr_q];
    assign count = cnt_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CNT_W'(DEPTH)));
    // R9
    push_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/apb_uart_tx_hold.sv
module apb_uart_tx_hold
    import apb_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] ldata,
    output logic              accept,
    output logic              busy,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    tx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)     state_d = TX_HOLD;
            TX_HOLD: if (tx_ready) state_d = TX_IDLE;
            default:               state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        busy     = 1'b0;
        tx_valid = 1'b0;
        unique case (state_q)
            TX_IDLE: accept = load;
            TX_HOLD: begin
                busy     = 1'b1;
                tx_valid = 1'b1;
            end
            default: accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= ldata;
    end

    assign tx_data = data_q;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R11
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy) |=> $stable(tx_data));
endmodule

// File: rtl/apb_uart_front.sv
module apb_uart_front
    import apb_uart_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [WORD_W-1:0] pwdata,
    output logic [WORD_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
    localparam int unsigned HALF_LVL = DEPTH / 2;

    logic              commit, wr_commit, rd_commit;
    reg_sel_e          sel;
    logic [WORD_W-1:0] ctrl_q, status;
    logic              dready_q, irq_q;
    logic              rx_push, rx_pop, rd_empty, fifo_empty;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              tx_load, tx_accept, tx_busy;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^paddr[ADDR_W-1:DEC_W];

    apb_uart_apb_fsm u_apb (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .commit  (commit)
    );

    assign sel       = decode_ofs(paddr[DEC_W-1:0]);
    assign wr_commit = commit && pwrite;
    assign rd_commit = commit && !pwrite;
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (wr_commit && sel == SEL_CTRL)  ctrl_q <= pwdata;
    end

    assign fifo_empty = (rx_count == '0);
    assign rx_ready   = ctrl_q[CTL_RXEN] && (rx_count != CNT_W'(DEPTH));
    assign rx_push    = rx_valid && rx_ready;
    assign rx_pop     = rd_commit && sel == SEL_DATA && !fifo_empty;
    assign rd_empty   = rd_commit && sel == SEL_DATA && fifo_empty;

    apb_uart_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_data),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                         dready_q <= 1'b0;
        else if (rx_push)                                   dready_q <= 1'b1;
        else if (rd_empty || (rx_pop && rx_count == CNT_W'(1))) dready_q <= 1'b0;
    end

    assign tx_load = wr_commit && sel == SEL_DATA && ctrl_q[CTL_TXEN];

    apb_uart_tx_hold u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .ldata    (pwdata[BYTE_W-1:0]),
        .accept   (tx_accept),
        .busy     (tx_busy),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready)
    );

    always_comb begin
        status             = '0;
        status[STB_DRDY]   = dready_q;
        status[STB_TSHE]   = !tx_busy;
        status[STB_TFE]    = !tx_busy;
        status[STB_TXFULL] = tx_busy;
        status[STB_RXHALF] = (rx_count >= CNT_W'(HALF_LVL));
        status[STB_RXFULL] = (rx_count == CNT_W'(DEPTH));
    end

    always_comb begin
        prdata = '0;
        unique case (sel)
            SEL_DATA: prdata = fifo_empty ? '0 : {{(WORD_W-BYTE_W){1'b0}}, rx_head};
            SEL_STAT: prdata = status;
            SEL_CTRL: prdata = ctrl_q;
            default:  prdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (rx_push && ctrl_q[CTL_RXIE]) || (tx_accept && ctrl_q[CTL_TXIE]);
    end

    assign irq = irq_q;

    // R7
    dready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dready_q == !fifo_empty);
    // R12
    irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_valid) && ctrl_q[CTL_TXIE]) |-> irq);
    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_RXEN] |-> !rx_ready);
endmodule

// File: tb/apb_uart_front_tb.sv
module apb_uart_front_tb;
    localparam int unsigned DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        irq;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [7:0]  rxq[$];
    logic [7:0]  txq[$];
    bit          tx_pend = 1'b0;
    logic [31:0] ctrl_m = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    apb_uart_front #(.DEPTH(DEPTH), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                       output logic [31:0] rdv);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rdv = prdata;
        check("R2 pready", {31'b0, pready}, 32'd1);
        check("R2 pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0]  = rxq.size() != 0;
        s[1]  = !tx_pend;
        s[2]  = !tx_pend;
        s[9]  = tx_pend;
        s[8]  = rxq.size() >= DEPTH / 2;
        s[10] = rxq.size() == DEPTH;
        return s;
    endfunction

    task automatic chk_status(input string req);
        logic [31:0] v;
        apb(1'b0, 12'h004, '0, v);
        check(req, v, exp_status());
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        logic [31:0] d;
        apb(1'b1, 12'h008, v, d);
        ctrl_m = v;
    endtask

    // scoreboard: receive bytes popped by data reads
    task automatic read_data(input logic [11:0] a, input string req);
        logic [31:0] v, e;
        apb(1'b0, a, '0, v);
        e = (rxq.size() != 0) ? {24'b0, rxq.pop_front()} : 32'd0;
        check(req, v, e);
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_data = b; rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        rxq.push_back(b);
    endtask

    // driver for transmit: expected bytes go to the queue
    task automatic write_data(input logic [31:0] v, input string req);
        logic [31:0] d;
        bit acc;
        acc = ctrl_m[1] && !tx_pend;
        apb(1'b1, 12'h000, v, d);
        if (acc) begin
            txq.push_back(v[7:0]);
            tx_pend = 1'b1;
        end
        check(req, {31'b0, irq}, {31'b0, acc && ctrl_m[3]});
    endtask

    // monitor for transmit handshakes
    always @(negedge clk) begin
        #2;
        if (rst_n && tx_valid && tx_ready) begin
            if (txq.size() == 0) check("R10 unexpected tx byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
            else                 check("R10 tx byte", {24'b0, tx_data}, {24'b0, txq.pop_front()});
            tx_pend = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'd0);
        check("R1 tx_valid in reset", {31'b0, tx_valid}, 32'd0);
        check("R1 rx_ready in reset", {31'b0, rx_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_status("R1 status after reset");
        apb(1'b0, 12'h008, '0, rd);
        check("R1 control after reset", rd, 32'd0);

        wr_ctrl(32'h8000_1FF0);
        apb(1'b0, 12'h008, '0, rd);
        check("R3 control readback", rd, 32'h8000_1FF0);
        check("R5 rx_ready with rx off", {31'b0, rx_ready}, 32'd0);

        apb(1'b1, 12'h004, 32'hFFFF_FFFF, rd);
        chk_status("R4 status write ignored");
        apb(1'b1, 12'h00C, 32'h0000_1234, rd);
        apb(1'b0, 12'h00C, '0, rd);
        check("R4 scaler reads zero", rd, 32'd0);
        apb(1'b0, 12'h010, '0, rd);
        check("R2 debug offset zero", rd, 32'd0);
        apb(1'b0, 12'h05C, '0, rd);
        check("R2 unmapped zero", rd, 32'd0);
        apb(1'b0, 12'h108, '0, rd);
        check("R2 high bits ignored", rd, 32'h8000_1FF0);

        wr_ctrl(32'h0);
        rx_data = 8'h99; rx_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 no accept when disabled", {31'b0, rx_ready}, 32'd0);
        end
        rx_valid = 1'b0;
        chk_status("R5 nothing stored");

        wr_ctrl(32'h5);
        check("R5 rx_ready when enabled", {31'b0, rx_ready}, 32'd1);
        send_rx(8'h11);
        check("R12 rx irq pulse", {31'b0, irq}, 32'd1);
        @(negedge clk);
        check("R12 rx irq one cycle", {31'b0, irq}, 32'd0);
        chk_status("R5 data ready set");
        send_rx(8'h22);
        send_rx(8'h33);
        read_data(12'h000, "R6 read offset 0");
        read_data(12'h003, "R6 read offset 3");
        read_data(12'h103, "R6 read alias");
        chk_status("R7 ready clear after last");
        read_data(12'h000, "R7 empty read");
        chk_status("R7 ready clear after empty read");

        for (int i = 0; i < DEPTH; i++) begin
            send_rx(8'hA0 + 8'(i));
            if (i == 1) chk_status("R8 half level");
        end
        check("R8 rx_ready low at full", {31'b0, rx_ready}, 32'd0);
        chk_status("R8 full level");
        rx_data = 8'hB4; rx_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 backpressure held", {31'b0, rx_ready}, 32'd0);
        end
        read_data(12'h000, "R8 read at full");
        check("R8 ready after read", {31'b0, rx_ready}, 32'd1);
        @(negedge clk);
        rx_valid = 1'b0;
        rxq.push_back(8'hB4);
        for (int i = 0; i < DEPTH; i++) read_data(12'h000, "R8 order after refill");

        send_rx(8'hC1);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h000;
        @(negedge clk);
        penable = 1'b1; rx_data = 8'hC2; rx_valid = 1'b1;
        #1;
        check("R9 read during push", prdata, {24'b0, rxq.pop_front()});
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; rx_valid = 1'b0;
        rxq.push_back(8'hC2);
        chk_status("R9 count kept");
        read_data(12'h000, "R9 pushed byte");
        read_data(12'h000, "R7 empty again");

        tx_ready = 1'b0;
        wr_ctrl(32'hA);
        write_data(32'h1234_56C3, "R12 tx irq pulse");
        check("R10 tx_valid", {31'b0, tx_valid}, 32'd1);
        check("R10 tx_data", {24'b0, tx_data}, 32'hC3);
        chk_status("R10 status pending");
        repeat (3) @(negedge clk);
        check("R10 held valid", {31'b0, tx_valid}, 32'd1);
        write_data(32'h77, "R11 no irq on drop");
        check("R11 pending byte kept", {24'b0, tx_data}, 32'hC3);
        tx_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 valid drops after ready", {31'b0, tx_valid}, 32'd0);
        chk_status("R10 status idle");
        write_data(32'h5A, "R12 tx irq with ready");
        @(negedge clk);

        wr_ctrl(32'h8);
        write_data(32'h66, "R11 disabled no irq");
        @(negedge clk);
        check("R11 disabled no output", {31'b0, tx_valid}, 32'd0);

        wr_ctrl(32'h1);
        send_rx(8'h44);
        check("R12 no irq when disabled", {31'b0, irq}, 32'd0);
        read_data(12'h000, "R6 last byte");
        check("R10 all tx bytes seen", txq.size(), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule